// File: doc/BRIEF.md
# Energize-Then-Hold Output Sequencer

This block sequences eight low-side gate enables. When a channel's enable bit rises, the channel drives its gate fully on for a programmable energizing interval. It then drops to a holding duty cycle, so that a relay, solenoid or motor winding runs cooler once it has pulled in. One 8-bit setting word is shared by all channels. It holds a hold-phase enable, a 3-bit duty code and a 4-bit interval code. The interval codes map to a fixed table of millisecond values.

The millisecond time base and the chopping time base come from two prescalers on the system clock. With the hold-phase enable clear and an interval programmed, the channel stays fully on unless a hold-start strobe arrives while its interval is still running. A global thermal shutdown input and per-channel overcurrent inputs force gates off immediately, without disturbing the sequencing state.

Top module: `energize_pwm_seq`

## Requirements
- R1: After reset every gate output is 0.
- R2: A channel whose enable bit is 0 has its gate at 0 no later than the next clock edge. This holds in every phase.
- R3: The setting word is laid out as bit 7 hold enable, bits 6:4 duty code and bits 3:0 interval code. With hold enable 0 and interval code 0, an enabled channel stays at 100% on indefinitely, and the hold-start strobe has no effect on it.
- R4: With hold enable 1 and interval code 0, an enabled channel enters chopping directly, with no fully-on interval.
- R5: Interval codes 1 to 15 select 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260 and 300 ms. The fully-on time lies in the range (T-1, T] ms ticks after the rising edge of the enable bit.
- R6: In chopping, the gate is high for duty code d out of every 8 chopping ticks, that is d/8 of each period.
- R7: With hold enable 1 and duty code 0, the gate stays at 0 after the interval expires.
- R8: With hold enable 0 and a nonzero interval code, a hold-start strobe during the interval moves the channel into chopping at the programmed duty.
- R9: With hold enable 0, once the interval has expired the channel stays at 100% on, and a later hold-start strobe has no effect.
- R10: Every 0-to-1 transition of a channel's enable bit restarts that channel's interval from its full value.
- R11: The thermal shutdown input forces all gates to 0, and an overcurrent input forces only its own channel's gate to 0. On release the gate resumes the phase the channel has reached.
- R12: Channels sequence independently. A channel already in its steady phase is not moved by another channel's enable edge or by a change of the setting word's interval fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 8 | Setting word: [7] hold enable, [6:4] duty code, [3:0] interval code |
| data_i | input | N_CH | Per-channel enable bits |
| pwm_start_i | input | 1 | Hold-start strobe, one cycle |
| force_off_i | input | 1 | Thermal shutdown, forces all gates off |
| ocp_i | input | N_CH | Per-channel overcurrent, forces that gate off |
| gate_o | output | N_CH | Gate enables |

## Verification
The bench builds the block with MS_DIV = 4 and PWM_DIV = 2. At these values the full 300 ms interval spans 1200 clocks and one chopping period spans 16 clocks. This makes it practical to sweep all fifteen interval codes and all eight duty codes in one run. The bench compares each measured fully-on time against the (T-1, T] tick window and each measured high count against d/8 of whole periods. It also covers the strobe-before-expiry case, the strobe-after-expiry case, restart of the interval and masking of the gates.

// File: rtl/eps_pkg.sv
package eps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ENRG = 2'd1,
    ST_CHOP = 2'd2,
    ST_FULL = 2'd3
  } ch_state_e;

  typedef struct packed {
    logic       hold_en;
    logic [2:0] duty;
    logic [3:0] tcode;
  } ctrl_t;

  localparam int MS_W = 9;

  function automatic logic [MS_W-1:0] enrg_ms(input logic [3:0] code);
    logic [MS_W-1:0] v;
    case (code)
      4'd1:    v = 9'd3;
      4'd2:    v = 9'd5;
      4'd3:    v = 9'd10;
      4'd4:    v = 9'd15;
      4'd5:    v = 9'd20;
      4'd6:    v = 9'd30;
      4'd7:    v = 9'd50;
      4'd8:    v = 9'd80;
      4'd9:    v = 9'd110;
      4'd10:   v = 9'd140;
      4'd11:   v = 9'd170;
      4'd12:   v = 9'd200;
      4'd13:   v = 9'd230;
      4'd14:   v = 9'd260;
      4'd15:   v = 9'd300;
      default: v = 9'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/eps_tick_gen.sv
module eps_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/eps_chan_seq.sv
module eps_chan_seq
  import eps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       data_i,
  input  ctrl_t      ctrl_i,
  input  logic       ms_tick_i,
  input  logic       start_i,
  input  logic [2:0] phase_i,
  input  logic       block_i,
  output logic       gate_o
);
  ch_state_e       st_q, st_d;
  logic [MS_W-1:0] rem_q, rem_d;
  logic            data_q;
  logic            rise;

  assign rise = data_i & ~data_q;

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    if (!data_i) begin
      st_d  = ST_IDLE;
      rem_d = '0;
    end else if (rise) begin
      // any fresh edge restarts the sequence
      if (ctrl_i.tcode != 4'd0) begin
        st_d  = ST_ENRG;
        rem_d = enrg_ms(ctrl_i.tcode);
      end else begin
        st_d  = ctrl_i.hold_en ? ST_CHOP : ST_FULL;
        rem_d = '0;
      end
    end else begin
      unique case (st_q)
        ST_ENRG: begin
          if (start_i && !ctrl_i.hold_en) begin
            st_d  = ST_CHOP;
            rem_d = '0;
          end else if (ms_tick_i) begin
            if (rem_q <= 9'd1) begin
              st_d  = ctrl_i.hold_en ? ST_CHOP : ST_FULL;
              rem_d = '0;
            end else begin
              rem_d = rem_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      data_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      data_q <= data_i;
    end
  end

  logic drive;
  always_comb begin
    unique case (st_q)
      ST_ENRG, ST_FULL: drive = 1'b1;
      ST_CHOP:          drive = (phase_i < ctrl_i.duty);
      default:          drive = 1'b0;
    endcase
  end

  assign gate_o = drive & ~block_i;

  a_r2_off_when_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_i |=> (st_q == ST_IDLE) && !gate_o);

  a_r5_interval_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= 9'd300);

  a_r9_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FULL) && data_i && data_q |=> (st_q == ST_FULL));

  a_r4_direct_chop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && ctrl_i.hold_en && (ctrl_i.tcode == 4'd0) |=> (st_q == ST_CHOP));

  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && (ctrl_i.tcode != 4'd0) |=> (st_q == ST_ENRG) && (rem_q != '0));
endmodule

// File: rtl/energize_pwm_seq.sv
module energize_pwm_seq
  import eps_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int MS_DIV  = 50000,
  parameter int PWM_DIV = 500
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      ctrl_i,
  input  logic [N_CH-1:0] data_i,
  input  logic            pwm_start_i,
  input  logic            force_off_i,
  input  logic [N_CH-1:0] ocp_i,
  output logic [N_CH-1:0] gate_o
);
  ctrl_t      ctrl;
  logic       ms_tick;
  logic       pwm_tick;
  logic [2:0] phase_q;

  assign ctrl = ctrl_t'(ctrl_i);

  eps_tick_gen #(.DIV(MS_DIV)) u_ms_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(ms_tick)
  );

  eps_tick_gen #(.DIV(PWM_DIV)) u_pwm_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(pwm_tick)
  );

  // 8-step chopping phase, one duty step per tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (pwm_tick) phase_q <= phase_q + 1'b1;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    eps_chan_seq u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .data_i   (data_i[g]),
      .ctrl_i   (ctrl),
      .ms_tick_i(ms_tick),
      .start_i  (pwm_start_i),
      .phase_i  (phase_q),
      .block_i  (force_off_i | ocp_i[g]),
      .gate_o   (gate_o[g])
    );
  end

  a_r11_thermal_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |-> (gate_o == '0));

  a_r11_ocp_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gate_o & ocp_i) == '0));

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (gate_o == '0));
endmodule

// File: tb/energize_pwm_seq_tb_top.sv
module energize_pwm_seq_tb_top;
  localparam int N_CH = 8;
  localparam int MSD  = 4;
  localparam int PWD  = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [7:0]      ctrl_i = '0;
  logic [N_CH-1:0] data_i = '0;
  logic            pwm_start_i = 1'b0;
  logic            force_off_i = 1'b0;
  logic [N_CH-1:0] ocp_i = '0;
  logic [N_CH-1:0] gate_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  energize_pwm_seq #(.N_CH(N_CH), .MS_DIV(MSD), .PWM_DIV(PWD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl_i), .data_i(data_i),
    .pwm_start_i(pwm_start_i), .force_off_i(force_off_i), .ocp_i(ocp_i),
    .gate_o(gate_o)
  );

  function automatic int ms_of(input int c);
    int t[16] = '{0, 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260, 300};
    return t[c];
  endfunction

  task automatic chk(input string rq, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp_v);
    end
  endtask

  task automatic chk_range(input string rq, input int act, input int lo, input int hi);
    n_chk++;
    if (act <= lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=(%0d,%0d]", rq, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count cycles gate[ch] stays high, sampled at negedges
  task automatic high_run(input int ch, output int h);
    h = 0;
    while (gate_o[ch] && h < 3000) begin
      h++;
      @(negedge clk);
    end
  endtask

  task automatic high_cnt(input int ch, input int win, output int h);
    h = 0;
    for (int i = 0; i < win; i++) begin
      if (gate_o[ch]) h++;
      @(negedge clk);
    end
  endtask

  task automatic strobe();
    pwm_start_i = 1'b1;
    cyc(1);
    pwm_start_i = 1'b0;
  endtask

  initial begin
    int h;
    @(negedge clk);
    chk("R1 reset gates", int'(gate_o), 0);
    cyc(2);
    rst_ni = 1'b1;
    cyc(3);
    chk("R1 gates idle after reset", int'(gate_o), 0);

    // R5 and R7: interval sweep, hold_en=1, duty 0
    for (int c = 1; c < 16; c++) begin
      ctrl_i = {1'b1, 3'd0, 4'(c)};
      data_i[0] = 1'b1;
      cyc(1);
      high_run(0, h);
      chk_range($sformatf("R5 interval code %0d", c), h + 1, (ms_of(c) - 1) * MSD, ms_of(c) * MSD + 1);
      high_cnt(0, 20, h);
      chk($sformatf("R7 off after expiry code %0d", c), h, 0);
      data_i[0] = 1'b0;
      cyc(2);
    end

    // R4 and R6: duty sweep, direct chopping
    for (int d = 0; d < 8; d++) begin
      ctrl_i = {1'b1, 3'(d), 4'd0};
      data_i[1] = 1'b1;
      cyc(3);
      high_cnt(1, 16 * PWD, h);
      chk($sformatf("R4 R6 duty %0d", d), h, d * 2 * PWD);
      data_i[1] = 1'b0;
      cyc(1);
      chk("R2 cleared channel off", int'(gate_o[1]), 0);
    end

    // R8: strobe during interval
    ctrl_i = {1'b0, 3'd4, 4'd5};
    data_i[2] = 1'b1;
    cyc(10);
    chk("R8 fully on before strobe", int'(gate_o[2]), 1);
    strobe();
    cyc(2);
    high_cnt(2, 16 * PWD, h);
    chk("R8 chopping after strobe", h, 8 * PWD);
    data_i[2] = 1'b0;
    cyc(2);

    // R9: strobe after expiry
    ctrl_i = {1'b0, 3'd4, 4'd1};
    data_i[3] = 1'b1;
    cyc(30);
    strobe();
    cyc(2);
    high_cnt(3, 16 * PWD, h);
    chk("R9 stays full after late strobe", h, 16 * PWD);

    // R3: no interval, no hold
    ctrl_i = {1'b0, 3'd2, 4'd0};
    data_i[4] = 1'b1;
    cyc(100);
    strobe();
    high_cnt(4, 16 * PWD, h);
    chk("R3 always on", h, 16 * PWD);

    // R12: ch4 steady full while another channel starts chopping
    ctrl_i = {1'b1, 3'd2, 4'd0};
    data_i[5] = 1'b1;
    cyc(3);
    high_cnt(5, 16 * PWD, h);
    chk("R12 new channel chops", h, 4 * PWD);
    chk("R12 steady channel undisturbed", int'(gate_o[4]), 1);
    data_i[5] = 1'b0;
    cyc(2);

    // R10: restart
    ctrl_i = {1'b1, 3'd0, 4'd2};
    data_i[6] = 1'b1;
    cyc(12);
    data_i[6] = 1'b0;
    cyc(1);
    data_i[6] = 1'b1;
    cyc(1);
    high_run(6, h);
    chk_range("R10 interval restarted", h + 1, 4 * MSD, 5 * MSD + 1);
    data_i[6] = 1'b0;

    // R11: masking, with ch3 and ch4 fully on
    force_off_i = 1'b1;
    cyc(1);
    chk("R11 thermal forces all off", int'(gate_o), 0);
    force_off_i = 1'b0;
    cyc(1);
    chk("R11 resume after thermal", int'(gate_o[4:3]), 3);
    ocp_i[3] = 1'b1;
    cyc(1);
    chk("R11 ocp masks own channel", int'(gate_o[4:3]), 2);
    ocp_i[3] = 1'b0;
    cyc(1);
    chk("R11 ocp release", int'(gate_o[4:3]), 3);

    data_i = '0;
    cyc(1);
    chk("R2 all cleared", int'(gate_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule